// File: doc/BRIEF.md
# Per-Core Temperature Read Responder

This block answers requests for a temperature reading. A request can name one processor core or the shared system-agent region. Every core carries several digital thermal sensors, and the block reports the hottest of them.

The block keeps one snapshot register per core and one for the system agent. All of them reload together on a 1 ms tick. Between ticks the sensor inputs may move freely without changing any answer. Requests read the snapshots only.

A requester raises a strobe with an 8-bit index. One cycle later the block returns a valid flag, a completion code and 16 bits of data. A run-time core count decides which indices are legal. An index outside that range is refused with an error completion code.

Temperatures are relative values. Each is a 16-bit two's-complement number in units of 1/64 °C. Zero is the maximum junction temperature, and cooler readings are negative.

Top module: `core_temp_responder`

## Requirements
- R1: For a legal core index c, the response data is the signed maximum of that core's sensors as held in the latest snapshot, with completion code 0x40. Sensor k of core c sits at bits [(c*SENSORS+k)*16 +: 16] of `sensor_flat`.
- R2: Index 0xFF returns the system-agent snapshot with code 0x40, whatever the core count is.
- R3: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. Back-to-back requests each get their own response.
- R4: Any index other than 0xFF that is not below the legal limit returns code 0x90 with data 0x0000.
- R5: The legal limit is the smaller of `core_count` and the number of cores built in. The limit takes effect in the same cycle that `core_count` changes.
- R6: Snapshots change only on a clock edge where `tick_1ms` is high. Sensor changes between ticks do not alter any response.
- R7: A request in the same cycle as a tick returns the value from before the tick. The next request returns the new value.
- R8: Sensor comparison is signed two's complement (1/64 °C, 0 = maximum junction temperature), so +1 °C (0x0040) beats −1 °C (0xFFC0).
- R9: While `rsp_valid` is low, `rsp_code` and `rsp_data` are both 0.
- R10: After reset all snapshots read 0x0000 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every 1 ms that reloads all snapshots |
| sensor_flat | input | NUM_CORES*SENSORS*16 | All core sensor readings, packed per R1 |
| sa_sensor | input | 16 | System-agent sensor reading |
| core_count | input | 8 | Number of cores present (run time) |
| req_valid | input | 1 | Request strobe |
| req_index | input | 8 | Core index, or 0xFF for the system agent |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 8 | Completion code: 0x40 success, 0x90 out of range |
| rsp_data | output | 16 | Relative temperature |

## Verification
The bench targets the boundary of the legal range. It reads the last legal core and the first illegal one at several core counts, including zero and counts above the number built in. A wrong comparison there would either hand back stale data for a missing core or refuse a real one.

It places a request on a tick cycle. A design that bypassed the snapshot would return the post-tick value one reading early. It changes sensors without a tick; an unregistered read path would show the change.

It mixes positive and negative readings within one core. An unsigned compare would then report −1 °C as hotter than +1 °C.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   localparam int          TEMP_W   = 16;
   localparam int          CODE_W   = 8;
   localparam logic [7:0]  CC_OK    = 8'h40;
   localparam logic [7:0]  CC_RANGE = 8'h90;

   typedef logic [TEMP_W-1:0] temp_t;
   typedef logic [CODE_W-1:0] code_t;

   typedef struct packed {
      logic  valid;
      code_t code;
      temp_t data;
   } rsp_t;
endpackage

// File: rtl/ctr_max_reduce.sv
module ctr_max_reduce #(
   parameter int N        = 4,
   parameter int W        = 16,
   parameter bit USE_TREE = 1'b1
) (
   input  logic [N-1:0][W-1:0] vals,
   output logic [W-1:0]        max_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   generate
      if (USE_TREE) begin : g_tree
         localparam int LV = (N > 1) ? $clog2(N) : 0;
         localparam int P  = 1 << LV;
         logic [W-1:0] node [1:2*P-1];
         for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < N) begin : g_real
               assign node[P+i] = vals[i];
            end else begin : g_pad
               assign node[P+i] = MOST_NEG;
            end
         end
         for (genvar n = P-1; n >= 1; n--) begin : g_node
            assign node[n] = ($signed(node[2*n]) >= $signed(node[2*n+1]))
                             ? node[2*n] : node[2*n+1];
         end
         assign max_o = node[1];
      end else begin : g_chain
         logic [W-1:0] acc [N];
         assign acc[0] = vals[0];
         for (genvar i = 1; i < N; i++) begin : g_step
            assign acc[i] = ($signed(vals[i]) > $signed(acc[i-1])) ? vals[i] : acc[i-1];
         end
         assign max_o = acc[N-1];
      end
   endgenerate
endmodule

// File: rtl/ctr_snapshot_bank.sv
module ctr_snapshot_bank #(
   parameter int NUM_CORES = 8,
   parameter int SENSORS   = 4,
   parameter int W         = 16,
   parameter bit USE_TREE  = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  tick,
   input  logic [NUM_CORES-1:0][SENSORS-1:0][W-1:0] sens,
   input  logic [W-1:0]                          sa_in,
   output logic [NUM_CORES-1:0][W-1:0]           core_snap,
   output logic [W-1:0]                          sa_snap
);
   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         logic [W-1:0] hottest;
         ctr_max_reduce #(.N(SENSORS), .W(W), .USE_TREE(USE_TREE)) u_max (
            .vals  (sens[c]),
            .max_o (hottest)
         );
         always_ff @(posedge clk) begin
            if (!rst_n)    core_snap[c] <= '0;
            else if (tick) core_snap[c] <= hottest;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    sa_snap <= '0;
      else if (tick) sa_snap <= sa_in;
   end
endmodule

// File: rtl/ctr_index_check.sv
module ctr_index_check #(
   parameter int NUM_CORES = 8,
   parameter int IDX_W     = 8,
   parameter int CNT_W     = 8,
   localparam int SEL_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [IDX_W-1:0] index,
   input  logic [CNT_W-1:0] core_count,
   output logic             is_sa,
   output logic             is_core,
   output logic [SEL_W-1:0] sel
);
   localparam logic [IDX_W-1:0] SA_INDEX = {IDX_W{1'b1}};

   int unsigned limit;

   always_comb begin
      limit   = (int'(core_count) > NUM_CORES) ? NUM_CORES : int'(core_count);
      is_sa   = (index == SA_INDEX);
      is_core = !is_sa && (int'(index) < limit);
      sel     = index[SEL_W-1:0];
   end
endmodule

// File: rtl/core_temp_responder.sv
module core_temp_responder #(
   parameter int NUM_CORES = 8,
   parameter int SENSORS   = 4,
   parameter int IDX_W     = 8,
   parameter int CNT_W     = 8,
   parameter bit USE_TREE  = 1'b1,
   localparam int W        = ctr_pkg::TEMP_W,
   localparam int SEL_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick_1ms,
   input  logic [NUM_CORES*SENSORS*W-1:0] sensor_flat,
   input  logic [W-1:0]                   sa_sensor,
   input  logic [CNT_W-1:0]               core_count,
   input  logic                           req_valid,
   input  logic [IDX_W-1:0]               req_index,
   output logic                           rsp_valid,
   output logic [7:0]                     rsp_code,
   output logic [W-1:0]                   rsp_data
);
   import ctr_pkg::*;

   generate
      if (NUM_CORES < 1 || NUM_CORES >= (1 << IDX_W) - 1) begin : g_bad_cores
         $error("NUM_CORES must fit below the system-agent index");
      end
      if (SENSORS < 1) begin : g_bad_sens
         $error("SENSORS must be at least 1");
      end
   endgenerate

   logic [NUM_CORES-1:0][SENSORS-1:0][W-1:0] sens_arr;
   logic [NUM_CORES-1:0][W-1:0]              core_snap;
   logic [W-1:0]                             sa_snap;
   logic                                     is_sa, is_core;
   logic [SEL_W-1:0]                         sel;
   rsp_t                                     rsp_q, rsp_d;

   assign sens_arr = sensor_flat;

   ctr_snapshot_bank #(
      .NUM_CORES(NUM_CORES), .SENSORS(SENSORS), .W(W), .USE_TREE(USE_TREE)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1ms),
      .sens      (sens_arr),
      .sa_in     (sa_sensor),
      .core_snap (core_snap),
      .sa_snap   (sa_snap)
   );

   ctr_index_check #(
      .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_idx (
      .index      (req_index),
      .core_count (core_count),
      .is_sa      (is_sa),
      .is_core    (is_core),
      .sel        (sel)
   );

   always_comb begin
      rsp_d = '0;
      if (req_valid) begin
         rsp_d.valid = 1'b1;
         if (is_sa) begin
            rsp_d.code = CC_OK;
            rsp_d.data = sa_snap;
         end else if (is_core) begin
            rsp_d.code = CC_OK;
            rsp_d.data = core_snap[sel];
         end else begin
            rsp_d.code = CC_RANGE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_q <= '0;
      else        rsp_q <= rsp_d;
   end

   assign rsp_valid = rsp_q.valid;
   assign rsp_code  = rsp_q.code;
   assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/ctr_resp_checker.sv
module ctr_resp_checker #(
   parameter int NUM_CORES = 8,
   parameter int IDX_W     = 8,
   parameter int CNT_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_1ms,
   input logic [CNT_W-1:0] core_count,
   input logic             req_valid,
   input logic [IDX_W-1:0] req_index,
   input logic             rsp_valid,
   input logic [7:0]       rsp_code,
   input logic [15:0]      rsp_data,
   input logic [15:0]      sa_snap
);
   localparam logic [IDX_W-1:0] SA_IDX = {IDX_W{1'b1}};
   int unsigned lim;
   assign lim = (int'(core_count) > NUM_CORES) ? NUM_CORES : int'(core_count);

   a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_code == 8'h00 && rsp_data == 16'h0000));

   a_r4_range_error: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_index != SA_IDX && int'(req_index) >= lim)
      |=> (rsp_code == 8'h90 && rsp_data == 16'h0000));

   a_r5_legal_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_index == SA_IDX || int'(req_index) < lim))
      |=> (rsp_code == 8'h40));

   a_r2_sa_data: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_index == SA_IDX) |=> (rsp_data == $past(sa_snap)));

   a_r6_sa_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_1ms |=> $stable(sa_snap));
endmodule

bind core_temp_responder ctr_resp_checker #(
   .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_1ms   (tick_1ms),
   .core_count (core_count),
   .req_valid  (req_valid),
   .req_index  (req_index),
   .rsp_valid  (rsp_valid),
   .rsp_code   (rsp_code),
   .rsp_data   (rsp_data),
   .sa_snap    (sa_snap)
);

// File: tb/core_temp_responder_bench.sv
`timescale 1ns/100ps
module core_temp_responder_bench;
   localparam int NC = 8;
   localparam int NS = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_1ms = 1'b0;
   logic [NC*NS*16-1:0] sensor_flat = '0;
   logic [15:0]       sa_sensor = '0;
   logic [7:0]        core_count = 8'd8;
   logic              req_valid = 1'b0;
   logic [7:0]        req_index = '0;
   logic              rsp_valid;
   logic [7:0]        rsp_code;
   logic [15:0]       rsp_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] ref_core [NC];
   logic [15:0] ref_sa;

   always #2.5 clk = ~clk;

   core_temp_responder u_core_temp_responder (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .sensor_flat(sensor_flat),
      .sa_sensor(sa_sensor), .core_count(core_count), .req_valid(req_valid),
      .req_index(req_index), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_data(rsp_data)
   );

   task automatic check(input string tag, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] core_max(input int c);
      logic [15:0] m = sensor_flat[(c*NS)*16 +: 16];
      for (int k = 1; k < NS; k++)
         if ($signed(sensor_flat[(c*NS+k)*16 +: 16]) > $signed(m))
            m = sensor_flat[(c*NS+k)*16 +: 16];
      return m;
   endfunction

   // One clock: apply inputs, predict, advance model, compare after the edge.
   task automatic cyc(input logic t, input logic r, input logic [7:0] idx, input string tag);
      logic        ev;
      logic [7:0]  ec;
      logic [15:0] ed;
      int          lim;
      tick_1ms = t; req_valid = r; req_index = idx;
      lim = (int'(core_count) > NC) ? NC : int'(core_count);
      ev = r; ec = 8'h00; ed = 16'h0000;
      if (r) begin
         if (idx == 8'hFF)        begin ec = 8'h40; ed = ref_sa; end
         else if (int'(idx) < lim) begin ec = 8'h40; ed = ref_core[idx]; end
         else                      begin ec = 8'h90; ed = 16'h0000; end
      end
      if (t) begin
         for (int c = 0; c < NC; c++) ref_core[c] = core_max(c);
         ref_sa = sa_sensor;
      end
      @(posedge clk); #1;
      check(r ? tag : "R9", "valid", {15'd0, rsp_valid}, {15'd0, ev});
      check(r ? tag : "R9", "code",  {8'd0, rsp_code}, {8'd0, ec});
      check(r ? tag : "R9", "data",  rsp_data, ed);
   endtask

   task automatic load_random();
      for (int i = 0; i < NC*NS; i++) sensor_flat[i*16 +: 16] = 16'($urandom);
      sa_sensor = 16'($urandom);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) ref_core[c] = '0;
      ref_sa = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10: reset state
      check("R10", "valid after reset", {15'd0, rsp_valid}, 16'd0);
      load_random();
      cyc(0, 1, 8'd0, "R10");          // snapshot still zero before any tick
      cyc(0, 1, 8'hFF, "R10");
      cyc(1, 0, 8'd0, "R6");           // first tick
      // R1: every core, R3 back-to-back
      for (int c = 0; c < NC; c++) cyc(0, 1, 8'(c), "R1");
      cyc(0, 1, 8'hFF, "R2");
      cyc(0, 0, 8'd0, "R9");
      // R4: beyond the built-in range
      cyc(0, 1, 8'd8, "R4");
      cyc(0, 1, 8'h80, "R4");
      cyc(0, 1, 8'hFE, "R4");
      // R5: run-time limits
      core_count = 8'd3;
      cyc(0, 1, 8'd2, "R5");
      cyc(0, 1, 8'd3, "R5");
      core_count = 8'd0;
      cyc(0, 1, 8'd0, "R5");
      cyc(0, 1, 8'hFF, "R2");
      core_count = 8'd12;
      cyc(0, 1, 8'd7, "R5");
      cyc(0, 1, 8'd8, "R5");
      core_count = 8'd8;
      // R6: sensors change without a tick
      load_random();
      for (int c = 0; c < NC; c++) cyc(0, 1, 8'(c), "R6");
      cyc(0, 1, 8'hFF, "R6");
      // R7: read on the tick cycle gets the old value, then the new one
      cyc(1, 1, 8'd5, "R7");
      cyc(0, 1, 8'd5, "R7");
      cyc(0, 1, 8'hFF, "R7");
      // R8: signed compare, +1 C must beat -1 C
      sensor_flat[(2*NS+0)*16 +: 16] = 16'hFFC0;
      sensor_flat[(2*NS+1)*16 +: 16] = 16'h0040;
      sensor_flat[(2*NS+2)*16 +: 16] = 16'h8000;
      sensor_flat[(2*NS+3)*16 +: 16] = 16'hFE00;
      for (int k = 0; k < NS; k++) sensor_flat[(4*NS+k)*16 +: 16] = 16'hFF00 + 16'(k);
      cyc(1, 0, 8'd0, "R8");
      cyc(0, 1, 8'd2, "R8");
      cyc(0, 1, 8'd4, "R8");
      // R3 / R9: mixed strobe pattern with random traffic
      for (int i = 0; i < 400; i++) begin
         logic t = ($urandom_range(0, 19) == 0);
         logic r = $urandom_range(0, 1) != 0;
         logic [7:0] ix = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 11));
         if ($urandom_range(0, 9) == 0) core_count = 8'($urandom_range(0, 10));
         if (t) load_random();
         cyc(t, r, ix, "R3");
      end
      cyc(0, 0, 8'd0, "R9");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule